// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small 8-bit processor core and decides when execution is redirected to an interrupt handler and to which address. It keeps a pending flag and an enable bit for each of its sources, gates them with one global enable bit, picks the most urgent enabled request and presents a vector address to the core. The vector table can sit at address zero or be moved as a whole to a boot-section base.

Two kinds of source are mixed, chosen per source by a parameter mask. Edge-type sources set a sticky flag that is remembered until the vector is taken or software clears it. Level-type sources have no memory and request service only while their condition input is high. The core reports five events: it accepts the request, it returns from a handler, it retires an instruction, it executes a global-disable instruction, or it executes a global-enable instruction. Taking a request clears the global enable. A return sets it again, but no request is offered until one main-program instruction has retired after the return.

Software reaches the flags and the enables through a one-bit-addressed write/read port. Address 0 is the pending view, where writing a one clears a flag. Address 1 holds the enable bits.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all flags and enables are clear, the global enable is 0 and no request is output.
- R2: An event on an edge-type source sets its flag, which stays set while its local enable or the global enable is off.
- R3: A write to address 0 clears each flag whose data bit is 1 and leaves flags under a 0 bit unchanged. If an event on the same source arrives in that cycle, the flag stays set.
- R4: A level-type source (default: sources 6 and 7) is pending only while its condition input is high. It keeps no memory. Bit i of a read at address 0 shows the pending state of source i.
- R5: Among the sources that are both pending and enabled, the one with the lowest source number is requested.
- R6: The vector address is base + 2*(i+1) for source i, because index 0 is reserved for reset. The base is 0 when tbl_sel_i is 0 and BOOT_BASE (default 0x7C00) when it is 1.
- R7: When ack_i arrives during a request, the global enable clears on the next edge. An edge-type source that is taken has its flag cleared, unless a new event arrives on that source in the same cycle.
- R8: reti_i sets the global enable. From the cycle after the return, no request is output until retire_i has been seen in a later cycle.
- R9: gie_clr_i suppresses the request in the same cycle and clears the global enable. gie_set_i sets it. Clearing wins over setting.
- R10: A write to address 1 stores the enable bits, and a read at address 1 returns them.
- R11: A request is output only when the global enable is 1 and some source is both pending and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 8 | Per-source event pulse (edge type) or condition level (level type) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = pending flags, 1 = enables |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| tbl_sel_i | input | 1 | Selects the boot-section vector base |
| gie_set_i | input | 1 | Global-enable instruction executed |
| gie_clr_i | input | 1 | Global-disable instruction executed |
| ack_i | input | 1 | Core takes the offered interrupt |
| reti_i | input | 1 | Return from interrupt executed |
| retire_i | input | 1 | Instruction retired |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 16 | Vector address in instruction words |
| gie_o | output | 1 | Global enable state |

## Verification
The bench targets collisions in a single cycle. An event that lands on a software or hardware clear must survive, or the interrupt is silently dropped. A disable instruction in the same cycle as a request must win, or a handler runs inside a protected sequence. The return-then-retire gate is checked by holding a pending request across a return: a design without the gate would re-enter at once and starve the main program. Level sources are checked to vanish when their condition drops before they are enabled, because a design that latches them would serve stale requests.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    REG_PEND = 1'b0,
    REG_EN   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int unsigned         NUM_SRC    = 8,
  parameter logic [NUM_SRC-1:0]  LEVEL_MASK = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic [NUM_SRC-1:0] sw_clr_i,
  input  logic [NUM_SRC-1:0] hw_clr_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      assign pend_o[i] = event_i[i];
    end else begin : g_flag
      logic flag_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= event_i[i] | (flag_q & ~sw_clr_i[i] & ~hw_clr_i[i]);
      end
      assign pend_o[i] = flag_q;

      // R2
      flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        event_i[i] |=> pend_o[i]);
      // R3
      flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sw_clr_i[i] && !event_i[i]) |=> !pend_o[i]);
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned NUM_SRC = 8,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] active_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  // R5
  winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (active_i[idx_o] &&
                 ((active_i & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1))) == '0)));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned        NUM_SRC    = 8,
  parameter int unsigned        PC_W       = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'b1100_0000,
  parameter logic [PC_W-1:0]    BOOT_BASE  = 16'h7C00,
  localparam int unsigned       IDX_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] event_i,
  input  logic               reg_we_i,
  input  logic               reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  input  logic               tbl_sel_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               ack_i,
  input  logic               reti_i,
  input  logic               retire_i,
  output logic               irq_req_o,
  output logic [PC_W-1:0]    irq_vec_o,
  output logic               gie_o
);
  import irq_pkg::*;

  logic [NUM_SRC-1:0] en_q, pend, active, sw_clr, hw_clr;
  logic               gie_q, hold_q, found, take;
  logic [IDX_W-1:0]   idx;
  reg_sel_e           sel;

  assign sel    = reg_sel_e'(reg_addr_i);
  assign sw_clr = (reg_we_i && sel == REG_PEND) ? reg_wdata_i : '0;
  assign hw_clr = take ? (NUM_SRC'(1) << idx) : '0;

  irq_pend #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (event_i),
    .sw_clr_i (sw_clr),
    .hw_clr_i (hw_clr),
    .pend_o   (pend)
  );

  assign active = pend & en_q;

  irq_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .found_o  (found),
    .idx_o    (idx)
  );

  // disable instruction blocks a request in its own cycle
  assign irq_req_o = found & gie_q & ~hold_q & ~gie_clr_i;
  assign take      = irq_req_o & ack_i;
  assign irq_vec_o = (tbl_sel_i ? BOOT_BASE : '0) + (PC_W'(idx) + PC_W'(1)) * PC_W'(2);
  assign gie_o     = gie_q;
  assign reg_rdata_o = (sel == REG_EN) ? en_q : pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (reg_we_i && sel == REG_EN) en_q <= reg_wdata_i;
      if (take || gie_clr_i)         gie_q <= 1'b0;
      else if (reti_i || gie_set_i)  gie_q <= 1'b1;
      // one main-program instruction must retire after a return
      if (reti_i)        hold_q <= 1'b1;
      else if (retire_i) hold_q <= 1'b0;
    end
  end

  // R7
  ack_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_req_o) |=> !gie_o);
  // R8
  reti_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !gie_clr_i && !(ack_i && irq_req_o)) |=> gie_o);
  // R8
  reti_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> !irq_req_o);
  // R9
  cli_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_clr_i |-> !irq_req_o);
  // R11
  req_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (gie_o && (pend & en_q) != '0));
endmodule

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] event_i = '0, wdata = '0;
  logic       we = 0, addr = 0, tbl_sel = 0, gie_set = 0, gie_clr = 0;
  logic       ack = 0, reti = 0, retire = 0;
  logic [7:0] rdata;
  logic       req, gie;
  logic [15:0] vec;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .event_i(event_i),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tbl_sel_i(tbl_sel), .gie_set_i(gie_set), .gie_clr_i(gie_clr),
    .ack_i(ack), .reti_i(reti), .retire_i(retire),
    .irq_req_o(req), .irq_vec_o(vec), .gie_o(gie)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, registers update at the following posedge
  task automatic tick();
    @(negedge clk);
    we = 0; ack = 0; reti = 0; retire = 0; gie_set = 0; gie_clr = 0; event_i[5:0] = '0;
    #1;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    we = 1; addr = a; wdata = d; tick();
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); chk("R1 flags", d, 0);
    rd(1, d); chk("R1 enables", d, 0);
    chk("R1 gie", gie, 0);
    chk("R1 req", req, 0);
  endtask

  task automatic t_latch_prio();
    logic [7:0] d;
    event_i[2] = 1; tick();
    rd(0, d); chk("R2 flag latched", d, 8'h04);
    chk("R11 no req, disabled", req, 0);
    wr(1, 8'h05);
    rd(1, d); chk("R10 enable readback", d, 8'h05);
    chk("R11 no req, gie off", req, 0);
    rd(0, d); chk("R2 flag held", d, 8'h04);
    gie_set = 1; tick();
    chk("R9 gie set", gie, 1);
    chk("R6 vec src2", vec, 16'd6);
    event_i[0] = 1; tick();
    chk("R5 lowest wins", vec, 16'd2);
    tbl_sel = 1; #1;
    chk("R6 boot base", vec, 16'h7C02);
    tbl_sel = 0; #1;
  endtask

  task automatic t_ack_reti();
    logic [7:0] d;
    chk("R7 req before ack", req, 1);
    ack = 1; tick();
    chk("R7 gie cleared", gie, 0);
    rd(0, d); chk("R7 taken flag cleared", d, 8'h04);
    chk("R7 no req", req, 0);
    reti = 1; tick();
    chk("R8 gie after reti", gie, 1);
    chk("R8 held after reti", req, 0);
    retire = 1; tick();
    chk("R8 released after retire", req, 1);
    chk("R8 vec src2", vec, 16'd6);
    event_i[2] = 1; ack = 1; tick();
    rd(0, d); chk("R7 event beats hw clear", d, 8'h04);
    chk("R7 gie cleared again", gie, 0);
  endtask

  task automatic t_w1c();
    logic [7:0] d;
    event_i[1] = 1; tick();
    wr(0, 8'h00);
    rd(0, d); chk("R3 zero write no effect", d, 8'h06);
    wr(0, 8'h02);
    rd(0, d); chk("R3 w1c", d, 8'h04);
    event_i[2] = 1; we = 1; addr = 0; wdata = 8'h04; tick();
    rd(0, d); chk("R3 event beats sw clear", d, 8'h04);
    wr(0, 8'h04);
    rd(0, d); chk("R3 cleared", d, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    event_i[6] = 1; tick();
    event_i[6] = 0; tick();
    rd(0, d); chk("R4 level not latched", d, 8'h00);
    wr(1, 8'h40); gie_set = 1; tick();
    chk("R4 lost level no req", req, 0);
    event_i[6] = 1; #1;
    chk("R4 level req", req, 1);
    chk("R6 vec src6", vec, 16'd14);
    rd(0, d); chk("R4 level visible", d, 8'h40);
    event_i[6] = 0; #1;
    chk("R4 level gone", req, 0);
  endtask

  task automatic t_cli();
    event_i[6] = 1; #1;
    chk("R11 req with gie", req, 1);
    gie_clr = 1; gie_set = 1; #1;
    chk("R9 cli blocks same cycle", req, 0);
    tick();
    chk("R9 clear beats set", gie, 0);
    chk("R9 no req after cli", req, 0);
    event_i[6] = 0;
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick();
    t_reset();
    @(negedge clk); rst_n = 1; tick();
    t_reset();
    t_latch_prio();
    t_ack_reti();
    t_w1c();
    t_level();
    t_cli();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule